// File: doc/BRIEF.md
# Multi-Block Erase Scheduler with Suspend

This block decides which storage blocks get erased and in what order. A host sends block-select pulses, each carrying a block index. The scheduler collects these into a pending bitmap and holds off for a selection window. Every new selection restarts that window. When the window runs out, the scheduler reads the per-block protect bits and drops every protected block, without raising an error. It then hands the remaining blocks one at a time, lowest index first, to an external per-block erase worker. The worker answers each block with a done pulse and a fail flag.

If every selected block turns out to be protected, the operation still looks as if it started, then ends on its own after a fixed interval. A suspend request acts at once while the window is still open. During erasing it takes effect only after a fixed settle delay, and the worker keeps running until then. A resume restarts erasing and may be repeated any number of times. An abort request drops the whole list and keeps the block busy for a fixed abort interval. All intervals are counted in clock cycles, derived from the clock frequency in MHz and a time in microseconds.

Top module: `erase_sched`

## Requirements
- R1: After reset, `busy`, `wk_run`, `tmr_started`, `suspended`, `op_done` and `op_err` are 0 and `pend_map` is all zero.
- R2: A select pulse with index i sets bit i of `pend_map`. `tmr_started` rises exactly WIN_CYC cycles after the last accepted select, and each select restarts that count.
- R3: Once `tmr_started` is 1, select pulses leave `pend_map` unchanged.
- R4: When the window expires, `pend_map` becomes the selected set with the blocks whose `blk_prot` bit is 1 removed. A removed block is never presented on `wk_blk`.
- R5: While `wk_run` is 1, `wk_blk` is the lowest set index of `pend_map`. A `wk_done` pulse clears that bit, and the next lowest index is presented in the following cycle.
- R6: When the last pending block completes, `op_done` pulses for one cycle with `busy` at 0. `op_err` is then the OR of every `wk_fail` sampled with `wk_done` during the operation, and stays until the next operation begins.
- R7: If every selected block is protected, `tmr_started` rises, `wk_run` stays 0, and `op_done` pulses NOPROT_CYC cycles after the window expiry with `op_err` at 0.
- R8: A suspend during the selection window sets `suspended` in the next cycle, with `tmr_started` at 0. Selects are then ignored. A resume starts erasing in the next cycle (`wk_run` and `tmr_started` at 1).
- R9: A suspend during erasing keeps `wk_run` at 1 for SUSP_CYC cycles and then sets `suspended` with `wk_run` at 0. A resume continues with the lowest pending block. This can be repeated.
- R10: An abort while busy clears `pend_map`, drops `wk_run` and `tmr_started` in the next cycle, and returns `busy` to 0 after ABORT_CYC cycles without an `op_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_vld | input | 1 | Block-select pulse |
| sel_idx | input | IW | Index of the selected block |
| blk_prot | input | NBLK | Per-block protect bits, sampled at window expiry |
| susp_req | input | 1 | Suspend request pulse |
| resume_req | input | 1 | Resume request pulse |
| abort_req | input | 1 | Abort (read/reset) request pulse |
| wk_done | input | 1 | Worker finished the presented block |
| wk_fail | input | 1 | Worker failure flag, valid with `wk_done` |
| wk_run | output | 1 | Worker should erase `wk_blk` |
| wk_blk | output | IW | Block currently being erased |
| pend_map | output | NBLK | Blocks still pending |
| tmr_started | output | 1 | Selection window has closed and the operation has launched |
| suspended | output | 1 | Operation is suspended |
| busy | output | 1 | An operation or abort is in progress |
| op_done | output | 1 | One-cycle pulse when an operation completes |
| op_err | output | 1 | Some erased block reported failure |

## Verification
The assertions assume three things about the worker and the inputs. The worker pulses `wk_done` for a single cycle and only while `wk_run` is 1. `blk_prot` holds still while an operation is in flight. Select indices lie below NBLK. The bench plays the worker itself: it raises `wk_done` only after seeing `wk_run` together with the expected `wk_blk`, changes `blk_prot` only while the block is idle, and sweeps every select mask against every protect mask of a four-block configuration. Directed sequences cover window restart, suspend in both phases, repeated resume and abort.

// File: rtl/es_pkg.sv
package es_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WIN    = 3'd1,
        ST_ERASE  = 3'd2,
        ST_SWAIT  = 3'd3,
        ST_SUSP   = 3'd4,
        ST_NOPROT = 3'd5,
        ST_ABORT  = 3'd6
    } es_state_e;
endpackage

// File: rtl/es_onehot.sv
module es_onehot #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [IW-1:0] idx,
    input  logic          en,
    output logic [N-1:0]  oh
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign oh[g] = en && (idx == IW'(g));
    end
endmodule

// File: rtl/es_lowest.sv
module es_lowest #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    always_comb begin
        idx = '0;
        any = |vec;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/erase_sched.sv
module erase_sched
    import es_pkg::*;
#(
    parameter int NBLK      = 11,
    parameter int CLK_MHZ   = 1,
    parameter int WIN_US    = 50,
    parameter int SUSP_US   = 15,
    parameter int ABORT_US  = 10,
    parameter int NOPROT_US = 100,
    localparam int IW = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sel_vld,
    input  logic [IW-1:0]   sel_idx,
    input  logic [NBLK-1:0] blk_prot,
    input  logic            susp_req,
    input  logic            resume_req,
    input  logic            abort_req,
    input  logic            wk_done,
    input  logic            wk_fail,
    output logic            wk_run,
    output logic [IW-1:0]   wk_blk,
    output logic [NBLK-1:0] pend_map,
    output logic            tmr_started,
    output logic            suspended,
    output logic            busy,
    output logic            op_done,
    output logic            op_err
);
    localparam int WIN_CYC    = CLK_MHZ * WIN_US;
    localparam int SUSP_CYC   = CLK_MHZ * SUSP_US;
    localparam int ABORT_CYC  = CLK_MHZ * ABORT_US;
    localparam int NOPROT_CYC = CLK_MHZ * NOPROT_US;
    localparam int MAX_A  = (WIN_CYC > SUSP_CYC) ? WIN_CYC : SUSP_CYC;
    localparam int MAX_B  = (ABORT_CYC > NOPROT_CYC) ? ABORT_CYC : NOPROT_CYC;
    localparam int MAXC   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW     = $clog2(MAXC + 1);
    localparam logic [CW-1:0] WIN_LD    = CW'(WIN_CYC - 1);
    localparam logic [CW-1:0] SUSP_LD   = CW'(SUSP_CYC - 1);
    localparam logic [CW-1:0] ABORT_LD  = CW'(ABORT_CYC - 1);
    localparam logic [CW-1:0] NOPROT_LD = CW'(NOPROT_CYC - 1);

    typedef struct packed {
        es_state_e       state;
        logic [NBLK-1:0] pend;
        logic [IW-1:0]   cur;
        logic [CW-1:0]   cnt;
        logic            launched;
        logic            done;
        logic            err;
    } regs_t;

    regs_t r_q, r_d;

    logic [NBLK-1:0] sel_oh, cur_oh, rem, elig;
    logic [IW-1:0]   rem_idx, elig_idx;
    logic            rem_any, elig_any, sel_any, go_abort;
    logic            do_launch, do_finish;

    es_onehot #(.N(NBLK), .IW(IW)) u_sel_dec (.idx(sel_idx), .en(sel_vld), .oh(sel_oh));
    es_onehot #(.N(NBLK), .IW(IW)) u_cur_dec (.idx(r_q.cur), .en(1'b1), .oh(cur_oh));

    assign rem  = r_q.pend & ~cur_oh;
    assign elig = r_q.pend & ~blk_prot;

    es_lowest #(.N(NBLK), .IW(IW)) u_rem_pick  (.vec(rem),  .idx(rem_idx),  .any(rem_any));
    es_lowest #(.N(NBLK), .IW(IW)) u_elig_pick (.vec(elig), .idx(elig_idx), .any(elig_any));

    assign sel_any  = |sel_oh;
    assign go_abort = abort_req && (r_q.state != ST_IDLE) && (r_q.state != ST_ABORT);

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        do_launch = 1'b0;
        do_finish = 1'b0;
        if (go_abort) begin
            r_d.state    = ST_ABORT;
            r_d.cnt      = ABORT_LD;
            r_d.pend     = '0;
            r_d.launched = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_IDLE: begin
                    if (sel_any) begin
                        r_d.pend  = sel_oh;
                        r_d.err   = 1'b0;
                        r_d.state = ST_WIN;
                        r_d.cnt   = WIN_LD;
                    end
                end
                ST_WIN: begin
                    if (susp_req) begin
                        r_d.state = ST_SUSP;
                    end else if (sel_any) begin
                        r_d.pend = r_q.pend | sel_oh;
                        r_d.cnt  = WIN_LD;
                    end else if (r_q.cnt == '0) begin
                        do_launch = 1'b1;
                    end else begin
                        r_d.cnt = r_q.cnt - 1'b1;
                    end
                end
                ST_ERASE, ST_SWAIT: begin
                    if (wk_done) begin
                        r_d.err  = r_q.err | wk_fail;
                        r_d.pend = rem;
                        r_d.cur  = rem_idx;
                        if (!rem_any) do_finish = 1'b1;
                    end
                    if (!do_finish) begin
                        if (r_q.state == ST_ERASE) begin
                            if (susp_req) begin
                                r_d.state = ST_SWAIT;
                                r_d.cnt   = SUSP_LD;
                            end
                        end else if (r_q.cnt == '0) begin
                            r_d.state = ST_SUSP;
                        end else begin
                            r_d.cnt = r_q.cnt - 1'b1;
                        end
                    end
                end
                ST_SUSP: begin
                    if (resume_req) begin
                        if (r_q.launched) r_d.state = ST_ERASE;
                        else              do_launch = 1'b1;
                    end
                end
                ST_NOPROT: begin
                    if (r_q.cnt == '0) do_finish = 1'b1;
                    else               r_d.cnt = r_q.cnt - 1'b1;
                end
                ST_ABORT: begin
                    if (r_q.cnt == '0) r_d.state = ST_IDLE;
                    else               r_d.cnt = r_q.cnt - 1'b1;
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
        if (do_launch) begin
            r_d.launched = 1'b1;
            r_d.pend     = elig;
            if (elig_any) begin
                r_d.state = ST_ERASE;
                r_d.cur   = elig_idx;
            end else begin
                r_d.state = ST_NOPROT;
                r_d.cnt   = NOPROT_LD;
            end
        end
        if (do_finish) begin
            r_d.state    = ST_IDLE;
            r_d.done     = 1'b1;
            r_d.launched = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign wk_run      = (r_q.state == ST_ERASE) || (r_q.state == ST_SWAIT);
    assign wk_blk      = r_q.cur;
    assign pend_map    = r_q.pend;
    assign tmr_started = r_q.launched;
    assign suspended   = (r_q.state == ST_SUSP);
    assign busy        = (r_q.state != ST_IDLE);
    assign op_done     = r_q.done;
    assign op_err      = r_q.err;

    p_sel_opens_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sel_vld && (32'(sel_idx) < NBLK)) |=> (busy && !tmr_started));

    p_list_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_started && !wk_done && !abort_req) |=> (pend_map == $past(pend_map)));

    p_cur_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wk_run |-> pend_map[wk_blk]);

    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> (!busy && !wk_run && (pend_map == '0)));

    p_win_susp_now_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.state == ST_WIN) && susp_req && !abort_req) |=> (suspended && !tmr_started));

    p_abort_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_req && busy && !op_done) |=> (!wk_run && (pend_map == '0) && busy));
endmodule

// File: tb/sim_erase_sched.sv
module sim_erase_sched;
    localparam int CLK_PER = 10;
    localparam int NB      = 4;
    localparam int WIN     = 50;
    localparam int SUSPC   = 15;
    localparam int ABT     = 10;
    localparam int NP      = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sel_vld = 1'b0;
    logic [1:0] sel_idx = '0;
    logic [NB-1:0] prot = '0;
    logic susp_req = 1'b0, resume_req = 1'b0, abort_req = 1'b0;
    logic wk_done = 1'b0, wk_fail = 1'b0;
    logic wk_run, tmr_started, suspended, busy, op_done, op_err;
    logic [1:0] wk_blk;
    logic [NB-1:0] pend_map;
    int checks = 0;
    int fails  = 0;

    always #(CLK_PER / 2) clk = ~clk;

    erase_sched #(.NBLK(NB), .CLK_MHZ(1), .WIN_US(WIN), .SUSP_US(SUSPC),
                  .ABORT_US(ABT), .NOPROT_US(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .sel_vld(sel_vld), .sel_idx(sel_idx),
        .blk_prot(prot), .susp_req(susp_req), .resume_req(resume_req),
        .abort_req(abort_req), .wk_done(wk_done), .wk_fail(wk_fail),
        .wk_run(wk_run), .wk_blk(wk_blk), .pend_map(pend_map),
        .tmr_started(tmr_started), .suspended(suspended), .busy(busy),
        .op_done(op_done), .op_err(op_err));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    task automatic sel(input int i);
        sel_vld = 1'b1;
        sel_idx = 2'(i);
        @(negedge clk);
        sel_vld = 1'b0;
    endtask

    task automatic pulse_susp();
        susp_req = 1'b1; @(negedge clk); susp_req = 1'b0;
    endtask

    task automatic pulse_resume();
        resume_req = 1'b1; @(negedge clk); resume_req = 1'b0;
    endtask

    task automatic finish_one(input logic fail);
        repeat (2) @(negedge clk);
        wk_done = 1'b1;
        wk_fail = fail;
        @(negedge clk);
        wk_done = 1'b0;
        wk_fail = 1'b0;
    endtask

    // acts as the worker for the blocks in el, checking ascending order
    task automatic serve(input logic [NB-1:0] el, input logic [NB-1:0] fm);
        logic [NB-1:0] rem;
        rem = el;
        while (rem != '0) begin
            int lo;
            lo = 0;
            for (int i = NB - 1; i >= 0; i--) if (rem[i]) lo = i;
            chk("R5 worker running", 32'(wk_run), 1);
            chk("R5 lowest pending block", 32'(wk_blk), 32'(lo));
            finish_one(fm[lo]);
            rem[lo] = 1'b0;
            if (rem != '0) chk("R5 bit cleared", 32'(pend_map), 32'(rem));
        end
        chk("R6 done pulse", 32'(op_done), 1);
        chk("R6 error flag", 32'(op_err), 32'(|(el & fm)));
        chk("R6 idle at done", 32'(busy), 0);
        @(negedge clk);
        chk("R6 done is one cycle", 32'(op_done), 0);
    endtask

    task automatic run_op(input logic [NB-1:0] sm, input logic [NB-1:0] pm, input logic [NB-1:0] fm);
        logic [NB-1:0] el;
        int spare;
        el = sm & ~pm;
        prot = pm;
        for (int i = 0; i < NB; i++) if (sm[i]) sel(i);
        chk("R2 pending after selects", 32'(pend_map), 32'(sm));
        repeat (WIN - 1) @(negedge clk);
        chk("R2 window still open", 32'(tmr_started), 0);
        @(negedge clk);
        chk("R2 window closed on time", 32'(tmr_started), 1);
        chk("R4 protected blocks dropped", 32'(pend_map), 32'(el));
        if (el == '0) begin
            chk("R7 no worker when all protected", 32'(wk_run), 0);
            repeat (NP - 1) @(negedge clk);
            chk("R7 still busy", 32'(busy), 1);
            chk("R7 no early done", 32'(op_done), 0);
            @(negedge clk);
            chk("R7 done after interval", 32'(op_done), 1);
            chk("R7 no error", 32'(op_err), 0);
            chk("R7 idle", 32'(busy), 0);
            @(negedge clk);
        end else begin
            spare = -1;
            for (int i = 0; i < NB; i++) if (!sm[i]) spare = i;
            if (spare >= 0) begin
                sel(spare);
                chk("R3 late select ignored", 32'(pend_map), 32'(el));
            end
            serve(el, fm);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all requirements act=hung exp=finished");
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 wk_run", 32'(wk_run), 0);
        chk("R1 pend_map", 32'(pend_map), 0);
        chk("R1 tmr_started", 32'(tmr_started), 0);
        chk("R1 suspended", 32'(suspended), 0);
        chk("R1 op_done", 32'(op_done), 0);
        chk("R1 op_err", 32'(op_err), 0);

        // R2 window restart with a gap between selects
        sel(0);
        repeat (20) @(negedge clk);
        sel(1);
        for (int i = 0; i < WIN - 1; i++) begin
            if (tmr_started) chk("R2 restart holds window", 32'(tmr_started), 0);
            @(negedge clk);
        end
        chk("R2 restarted window open", 32'(tmr_started), 0);
        @(negedge clk);
        chk("R2 restarted window closed", 32'(tmr_started), 1);
        serve(4'b0011, 4'b0000);

        // R8 suspend inside the window
        sel(1);
        repeat (5) @(negedge clk);
        pulse_susp();
        chk("R8 suspended at once", 32'(suspended), 1);
        chk("R8 timer not started", 32'(tmr_started), 0);
        repeat (80) @(negedge clk);
        chk("R8 stays suspended", 32'(suspended), 1);
        chk("R8 no launch while suspended", 32'(tmr_started), 0);
        sel(2);
        chk("R8 select ignored while suspended", 32'(pend_map), 32'(4'b0010));
        pulse_resume();
        chk("R8 erasing at once", 32'(wk_run), 1);
        chk("R8 timer started", 32'(tmr_started), 1);
        chk("R8 block presented", 32'(wk_blk), 1);
        serve(4'b0010, 4'b0010);

        // R9 suspend during erasing, twice
        sel(0);
        sel(2);
        repeat (WIN) @(negedge clk);
        chk("R9 first block", 32'(wk_blk), 0);
        pulse_susp();
        repeat (SUSPC - 1) @(negedge clk);
        chk("R9 worker runs during settle", 32'(wk_run), 1);
        chk("R9 not yet suspended", 32'(suspended), 0);
        @(negedge clk);
        chk("R9 suspended after settle", 32'(suspended), 1);
        chk("R9 worker stopped", 32'(wk_run), 0);
        repeat (5) @(negedge clk);
        pulse_resume();
        chk("R9 resumed same block", 32'(wk_blk), 0);
        chk("R9 running after resume", 32'(wk_run), 1);
        finish_one(1'b0);
        chk("R9 next block", 32'(wk_blk), 2);
        pulse_susp();
        repeat (SUSPC) @(negedge clk);
        chk("R9 suspended again", 32'(suspended), 1);
        pulse_resume();
        chk("R9 resumed again", 32'(suspended), 0);
        serve(4'b0100, 4'b0000);

        // R10 abort
        sel(3);
        repeat (WIN) @(negedge clk);
        chk("R10 erasing before abort", 32'(wk_run), 1);
        abort_req = 1'b1;
        @(negedge clk);
        abort_req = 1'b0;
        chk("R10 worker dropped", 32'(wk_run), 0);
        chk("R10 list cleared", 32'(pend_map), 0);
        chk("R10 timer flag cleared", 32'(tmr_started), 0);
        for (int i = 0; i < ABT - 1; i++) begin
            if (op_done) chk("R10 no done during abort", 32'(op_done), 0);
            @(negedge clk);
        end
        chk("R10 busy through interval", 32'(busy), 1);
        @(negedge clk);
        chk("R10 idle after interval", 32'(busy), 0);
        chk("R10 no done pulse", 32'(op_done), 0);

        // sweep: every select mask against every protect mask
        for (int s = 1; s < 16; s++) begin
            for (int p = 0; p < 16; p++) begin
                run_op(4'(s), 4'(p), 4'b0100);
            end
        end
        prot = '0;

        report();
        $finish;
    end
endmodule